// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block decides which of five interrupt sources of a 16550-style serial port is reported to the processor. It also produces the single interrupt request line. It takes the four enable bits, the line status flags, the receive FIFO fill count, and the trigger-level selector. It also takes the transmit-empty state, a strobe that marks a character moving into the transmit shifter, and the modem delta flags. From these it forms a four-bit identification value. The priority of the sources is fixed.

Two pieces of state live inside the block. The first is a character-timeout counter. It advances on each baud tick while received data waits, and a read of the receive buffer clears it. The timeout source fires once the counter reaches a parameter multiple of the programmed character time. The second is a transmit-empty pending flag. It is set when a character leaves the transmit buffer. It is cleared when software reads the identification value while that value shows transmit-empty.

Top module: `uart_irq_ident`

## Requirements
- R1: Out of reset, and whenever no source is active, `irq_id` is 4'b0001 and `irq` is low; reset also zeroes the timeout counter and the pending flag.
- R2: With `ier[2]` set and any of `lsr[1]` (overrun), `lsr[2]` (parity), `lsr[3]` (framing) or `lsr[4]` (break) set, `irq_id` is 4'b0110, whatever other sources are active.
- R3: With `ier[0]` set, `lsr[0]` (data ready) set and `rx_count` at or above the trigger level, `irq_id` is 4'b0100 unless R2 applies. The trigger levels are: `trig_sel` 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, and 3 gives DEPTH-2.
- R4: The timeout counter increments by one at each clock with `tick` and `lsr[0]` both high, and saturates at its maximum. It returns to zero one clock after `rx_read`, and `rx_read` wins over an increment.
- R5: With `ier[0]` set and the timeout counter at or above TO_MULT times `char_time`, `irq_id` is 4'b1100 unless R2 or R3 applies.
- R6: The pending flag is set in the clock after `tx_load`. With `ier[1]`, `tx_empty` and the pending flag all set, `irq_id` is 4'b0010 unless R2, R3 or R5 applies.
- R7: `iir_read` while `irq_id` is 4'b0010 clears the pending flag at the next clock unless `tx_load` is also high. `iir_read` while `irq_id` shows any other value leaves the flag unchanged.
- R8: With `ier[3]` set and any bit of `modem_delta` set, `irq_id` is 4'b0000, but only when no other source applies.
- R9: `irq` is high exactly when `irq_id` differs from 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Enables: 0 rx data/timeout, 1 tx empty, 2 line status, 3 modem |
| lsr | input | 5 | 0 data ready, 1 overrun, 2 parity, 3 framing, 4 break |
| rx_count | input | CNT_W | Receive FIFO fill count |
| trig_sel | input | 2 | Receive trigger-level selector |
| tx_empty | input | 1 | Transmit buffer empty |
| tx_load | input | 1 | Character moved from buffer into shifter |
| modem_delta | input | 4 | Modem change flags |
| char_time | input | CT_W | Character time in ticks |
| tick | input | 1 | Baud-rate tick enable |
| rx_read | input | 1 | Receive buffer read strobe |
| iir_read | input | 1 | Identification register read strobe |
| irq_id | output | 4 | Identification value |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to reach is a timeout interrupt that is actually visible. The counter has to climb past TO_MULT times the character time while data-ready stays high, and neither a receive read nor a line error or trigger-level hit may hide it. The stimulus programs short character times and holds `tick` high during dedicated phases. In those phases `rx_read` is rare and the FIFO count is kept below the trigger, so the counter passes the threshold and then gets cleared. The pending-flag clear also needs a read that lands exactly while 4'b0010 is on the output. For this, `iir_read` is pulsed often while the higher sources are held quiet.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'b0000,
        ID_NONE    = 4'b0001,
        ID_TXEMPTY = 4'b0010,
        ID_RXDATA  = 4'b0100,
        ID_LINE    = 4'b0110,
        ID_TIMEOUT = 4'b1100
    } irq_id_e;

    localparam int NSRC = 5;

    // MSB is the highest priority source
    typedef struct packed {
        logic line;
        logic rxdata;
        logic timeout;
        logic txempty;
        logic modem;
    } src_req_t;

    function automatic irq_id_e code_of(input int idx);
        case (idx)
            4:       return ID_LINE;
            3:       return ID_RXDATA;
            2:       return ID_TIMEOUT;
            1:       return ID_TXEMPTY;
            default: return ID_MODEM;
        endcase
    endfunction

    function automatic int trig_level(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
    parameter int CT_W    = 12,
    parameter int TO_MULT = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            data_ready,
    input  logic            rx_read,
    input  logic [CT_W-1:0] char_time,
    output logic            expired
);
    localparam int TO_W = CT_W + $clog2(TO_MULT) + 1;

    logic [TO_W-1:0] cnt_q;
    logic [TO_W-1:0] thresh;

    assign thresh  = TO_W'(char_time) * TO_W'(TO_MULT);
    assign expired = (cnt_q >= thresh);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (rx_read)
            cnt_q <= '0;
        else if (tick && data_ready && (cnt_q != {TO_W{1'b1}}))
            cnt_q <= cnt_q + 1'b1;
    end

    AST_TO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rx_read |=> (cnt_q == '0)); // R4
    AST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!rx_read && !(tick && data_ready)) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend (
    input  logic clk,
    input  logic rst,
    input  logic tx_load,
    input  logic ack,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (tx_load)
            pend <= 1'b1;
        else if (ack)
            pend <= 1'b0;
    end

    AST_PEND_SET: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> pend); // R6
    AST_PEND_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!tx_load && !ack) |=> $stable(pend)); // R7

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  src_req_t req,
    output irq_id_e  id
);
    logic [NSRC-1:0] req_v;
    logic [NSRC-1:0] grant;

    assign req_v = req;

    for (genvar i = 0; i < NSRC; i++) begin : g_grant
        if (i == NSRC - 1) begin : g_top
            assign grant[i] = req_v[i];
        end else begin : g_low
            assign grant[i] = req_v[i] & ~(|req_v[NSRC-1:i+1]);
        end
    end

    always_comb begin
        id = ID_NONE;
        for (int k = 0; k < NSRC; k++)
            if (grant[k]) id = code_of(k);
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CNT_W   = $clog2(DEPTH + 1),
    parameter int CT_W    = 12,
    parameter int TO_MULT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       ier,
    input  logic [4:0]       lsr,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             tx_empty,
    input  logic             tx_load,
    input  logic [3:0]       modem_delta,
    input  logic [CT_W-1:0]  char_time,
    input  logic             tick,
    input  logic             rx_read,
    input  logic             iir_read,
    output logic [3:0]       irq_id,
    output logic             irq
);
    localparam int LVL_W = CNT_W + 1;

    src_req_t        req;
    irq_id_e         id;
    logic            to_expired;
    logic            pend;
    logic            ack;
    logic [LVL_W-1:0] level;

    assign level = LVL_W'(trig_level(trig_sel, DEPTH));

    uart_irq_timeout #(.CT_W(CT_W), .TO_MULT(TO_MULT)) u_timeout (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .data_ready (lsr[0]),
        .rx_read    (rx_read),
        .char_time  (char_time),
        .expired    (to_expired)
    );

    assign ack = iir_read && (id == ID_TXEMPTY);

    uart_irq_pend u_pend (
        .clk     (clk),
        .rst     (rst),
        .tx_load (tx_load),
        .ack     (ack),
        .pend    (pend)
    );

    always_comb begin
        req.line    = ier[2] && (|lsr[4:1]);
        req.rxdata  = ier[0] && lsr[0] && (LVL_W'(rx_count) >= level);
        req.timeout = ier[0] && to_expired;
        req.txempty = ier[1] && tx_empty && pend;
        req.modem   = ier[3] && (|modem_delta);
    end

    uart_irq_prio u_prio (
        .req (req),
        .id  (id)
    );

    assign irq_id = id;
    assign irq    = (id != ID_NONE);

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        (ier[2] && |lsr[4:1]) |-> (irq_id == 4'b0110)); // R2
    AST_RXDATA_COND: assert property (@(posedge clk) disable iff (rst)
        (irq_id == 4'b0100) |-> (lsr[0] && ier[0])); // R3
    AST_MODEM_LAST: assert property (@(posedge clk) disable iff (rst)
        (irq_id == 4'b0000) |-> (ier[3] && |modem_delta && !(ier[2] && |lsr[4:1]))); // R8
    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_id != 4'b0001)); // R9

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH   = 16;
    localparam int CNT_W   = 5;
    localparam int CT_W    = 12;
    localparam int TO_MULT = 4;
    localparam int TO_MAX  = (1 << (CT_W + 2 + 1)) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       ier = '0;
    logic [4:0]       lsr = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic [1:0]       trig_sel = '0;
    logic             tx_empty = 1'b0;
    logic             tx_load = 1'b0;
    logic [3:0]       modem_delta = '0;
    logic [CT_W-1:0]  char_time = 12'd3;
    logic             tick = 1'b0;
    logic             rx_read = 1'b0;
    logic             iir_read = 1'b0;
    logic [3:0]       irq_id;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    int m_cnt = 0;
    bit m_pend = 0;
    int exp_id;

    uart_irq_ident #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CT_W(CT_W), .TO_MULT(TO_MULT)) u_dut (
        .clk(clk), .rst(rst), .ier(ier), .lsr(lsr), .rx_count(rx_count),
        .trig_sel(trig_sel), .tx_empty(tx_empty), .tx_load(tx_load),
        .modem_delta(modem_delta), .char_time(char_time), .tick(tick),
        .rx_read(rx_read), .iir_read(iir_read), .irq_id(irq_id), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int level_of(input logic [1:0] s);
        if (s == 0) return 1;
        if (s == 1) return DEPTH / 4;
        if (s == 2) return DEPTH / 2;
        return DEPTH - 2;
    endfunction

    function automatic int model_id();
        if (ier[2] && (lsr[1] || lsr[2] || lsr[3] || lsr[4])) return 6;   // R2
        if (ier[0] && lsr[0] && int'(rx_count) >= level_of(trig_sel)) return 4; // R3
        if (ier[0] && m_cnt >= TO_MULT * int'(char_time)) return 12;      // R5
        if (ier[1] && tx_empty && m_pend) return 2;                        // R6
        if (ier[3] && modem_delta != 0) return 0;                          // R8
        return 1;                                                          // R1
    endfunction

    function automatic string req_of(input int id);
        case (id)
            6: return "R2";
            4: return "R3";
            12: return "R5/R4";
            2: return "R6/R7";
            0: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic compare(input string tag);
        exp_id = model_id();
        n_cmp++;
        if (int'(irq_id) != exp_id) begin
            n_bad++;
            $display("FAIL %s irq_id actual=%b expected=%b t=%0t", tag, irq_id, exp_id[3:0], $time);
        end
        n_cmp++;
        if (irq !== (exp_id != 1)) begin
            n_bad++;
            $display("FAIL R9 irq actual=%b expected=%b t=%0t", irq, exp_id != 1, $time);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_cnt = 0; m_pend = 0;
        end else begin
            if (tx_load) m_pend = 1;
            else if (iir_read && exp_id == 2) m_pend = 0;
            if (rx_read) m_cnt = 0;
            else if (tick && lsr[0] && m_cnt < TO_MAX) m_cnt++;
        end
    endtask

    // one cycle: inputs already driven after negedge; compare then advance model
    task automatic cycle(input string tag);
        #1;
        if (rst) exp_id = 1; else compare(tag == "" ? req_of(model_id()) : tag);
        model_step();
        @(negedge clk);
    endtask

    task automatic quiet();
        ier = '0; lsr = '0; rx_count = '0; tx_empty = 0; tx_load = 0;
        modem_delta = '0; tick = 0; rx_read = 0; iir_read = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1; cycle(""); cycle("");
        rst = 0;
        ier = 4'hF; cycle("R1");              // reset state: nothing active
        // R2 over everything
        lsr = 5'b11111; rx_count = 16; tx_empty = 1; modem_delta = 4'hF; cycle("R2");
        // R3 each trigger level at and below boundary
        for (int s = 0; s < 4; s++) begin
            quiet(); ier = 4'h1; lsr = 5'b00001; trig_sel = 2'(s);
            rx_count = CNT_W'(level_of(2'(s))); cycle("R3");
            rx_count = CNT_W'(level_of(2'(s)) - 1); cycle("R3");
            rx_read = 1; cycle("R4"); rx_read = 0;
        end
        // R4/R5: timeout build up with char_time 2
        quiet(); char_time = 12'd2; ier = 4'h1; lsr = 5'b00001; rx_count = 0; trig_sel = 2'd3;
        tick = 1;
        for (int k = 0; k < 12; k++) cycle("R5");
        tick = 0; rx_read = 1; cycle("R4"); rx_read = 0; cycle("R4");
        // R6/R7 pending flag
        quiet(); ier = 4'h2; tx_empty = 1; cycle("R6");
        tx_load = 1; cycle("R6"); tx_load = 0; cycle("R6");
        modem_delta = 4'h1; ier = 4'hA; iir_read = 1; cycle("R7"); iir_read = 0;
        cycle("R8");
        tx_load = 1; cycle("R6"); tx_load = 0;
        lsr = 5'b00010; ier = 4'hE; iir_read = 1; cycle("R7"); iir_read = 0;
        lsr = 0; cycle("R7");
        // randomized phases
        for (int ph = 0; ph < 6; ph++) begin
            char_time = CT_W'(1 + $urandom_range(0, 6));
            for (int k = 0; k < 600; k++) begin
                ier         = 4'($urandom);
                lsr[0]      = ($urandom_range(0, 3) != 0);
                lsr[4:1]    = (ph < 2 && $urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
                rx_count    = (ph % 2 == 0) ? CNT_W'($urandom_range(0, DEPTH)) : CNT_W'(0);
                trig_sel    = 2'($urandom);
                tx_empty    = ($urandom_range(0, 2) != 0);
                tx_load     = ($urandom_range(0, 15) == 0);
                modem_delta = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
                tick        = ($urandom_range(0, 1) == 0);
                rx_read     = ($urandom_range(0, 40) == 0);
                iir_read    = ($urandom_range(0, 3) == 0);
                cycle("");
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule